// File: doc/BRIEF.md
# Configuration Address Translator

This block sits between a host register bus and a downstream configuration-access port. Software programs a 32-bit index register through one 4 KB host window, then reads or writes a second 4 KB window, the data window. Every data-window access turns the index value held at that moment, together with the low bits of the access offset, into a standard bus/device/function/register configuration address. The block then issues a single sized read or write on the downstream port.

Three index encodings are recognised. If bit 31 is set, the index passes through almost untouched. If bit 31 is clear and bit 0 is set, the index is treated as an already-formed Type-1 style address. If both bits are clear, the upper field is a one-hot slot select: the lowest set bit gives the device number. The translation logic is combinational. Its result is captured in a single registered output stage together with the rest of the downstream request. The request is held until the downstream side accepts it. The host access completes with a one-cycle acknowledge.

Top module: `cfg_addr_xlate`

## Requirements
- R1: While reset is high and in the first cycle after it, `dn_valid` and `host_ack` are low, and the index register reads back as zero.
- R2: Index-window writes are little-endian by byte lane. A 1-byte write (size 00) updates lane `off[1:0]`, a 2-byte write (size 01) updates lanes `{off[1],0}` and `{off[1],1}`, and a 4-byte write (size 10 or 11) updates all lanes. Reads return the addressed lanes right-justified. Offset bits 11:2 select nothing, so the register appears at every word of its window.
- R3: With index bit 31 set, the downstream address equals the index ORed with access-offset bits 1:0.
- R4: With index bit 31 clear and bit 0 set, the downstream address is the index with bits 2:0 replaced by access-offset bits 2:0.
- R5: With index bits 31 and 0 both clear and at least one of index bits 31:11 set, the address holds the position (11..31) of the lowest set bit among index bits 31:11 in bits 15:11, index bits 10:8 in bits 10:8, index bits 7:3 in bits 7:3 and offset bits 2:0 in bits 2:0. Bits 31:16 are zero.
- R6: In the one-hot encoding with index bits 31:11 all clear, address bits 31:11 are all ones; the low 11 bits are formed as in R5.
- R7: A downstream request keeps `dn_valid`, `dn_addr`, `dn_wr`, `dn_size` and `dn_wdata` stable until a cycle with `dn_ready` high. `host_ack` rises in the next cycle and stays high for exactly one cycle. This holds for any number of wait cycles.
- R8: `dn_size` carries the access size (00 one byte, 01 two bytes, 10 four bytes; the code 11 is forwarded as 10). Write data is masked to the size, read data is returned masked to the size and right-justified, and a data-window write returns zero on `host_rdata`.
- R9: The translation uses the index value current when the data access is accepted, so an index write followed directly by a data access uses the new value.
- R10: Data-window offset bits 11:3 never change the downstream address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = index window, 1 = data window |
| host_off | input | OFF_W | Byte offset within the selected window |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Right-justified write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Right-justified read data, valid with `host_ack` |
| dn_valid | output | 1 | Downstream request valid |
| dn_wr | output | 1 | Downstream write flag |
| dn_addr | output | 32 | Translated configuration address |
| dn_size | output | 2 | Downstream access size code |
| dn_wdata | output | 32 | Size-masked write data |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_rdata | input | 32 | Downstream read data, valid with `dn_ready` |

## Verification
The bench goes after the edges of the slot search. It uses a slot bit at position 11, a slot bit at position 30, two set bits where only the lower one may count, and an empty slot field. A wrong search would report the higher bit, an off-by-eleven number, or zeros instead of the all-ones slot. It also checks mode priority on indices that have both bit 31 and bit 0 set. It drives offsets whose upper bits are set, to catch a translator that mixes in too many offset bits. Finally it steps through the byte lanes of the index register and uses long downstream wait states, so that a lane swap, a request that drifts before `dn_ready`, or an acknowledge held too long shows up at the ports.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int CFG_W    = 32;
  localparam int LANES    = CFG_W / 8;
  localparam int SLOT_LSB = 11;
  localparam int FUNC_LSB = 8;
  localparam int FUNC_W   = 3;
  localparam int REG_LSB  = 3;
  localparam int SEL_W    = CFG_W - SLOT_LSB;
  localparam int POS_W    = $clog2(CFG_W);

  typedef enum logic [1:0] {
    SZ_B1  = 2'b00,
    SZ_B2  = 2'b01,
    SZ_B4  = 2'b10,
    SZ_RSV = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    MAP_PASS   = 2'b00,
    MAP_TYPE1  = 2'b01,
    MAP_ONEHOT = 2'b10
  } map_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_DONE = 2'b10
  } ctl_state_e;

  function automatic xfer_size_e norm_size(input logic [1:0] code);
    xfer_size_e s;
    s = xfer_size_e'(code);
    if (s == SZ_RSV) s = SZ_B4;
    return s;
  endfunction

  function automatic logic [CFG_W-1:0] size_mask(input xfer_size_e s);
    case (s)
      SZ_B1:   return CFG_W'(32'h0000_00FF);
      SZ_B2:   return CFG_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [1:0] lane_shift(input xfer_size_e s, input logic [1:0] off);
    case (s)
      SZ_B1:   return off;
      SZ_B2:   return {off[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_en(input xfer_size_e s, input logic [1:0] off);
    case (s)
      SZ_B1:   return LANES'(1) << lane_shift(s, off);
      SZ_B2:   return LANES'(3) << lane_shift(s, off);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/cfgx_lowbit_find.sv
module cfgx_lowbit_find #(
  parameter int W    = 21,
  parameter int BASE = 11,
  parameter int PW   = 5
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [PW-1:0] pos
);
  logic [W-1:0] below;
  logic [W-1:0] first;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lo
        assign below[i] = 1'b0;
      end else begin : g_hi
        assign below[i] = |vec[i-1:0];
      end
      assign first[i] = vec[i] & ~below[i];
    end
  endgenerate

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) pos = pos | PW'(BASE + i);
    end
  end

  assign hit = |vec;
endmodule

// File: rtl/cfgx_addr_map.sv
module cfgx_addr_map
  import cfgx_pkg::*;
(
  input  logic [CFG_W-1:0] idx,
  input  logic [2:0]       off_lo,
  output logic [CFG_W-1:0] addr
);
  map_mode_e          mode;
  logic               slot_hit;
  logic [POS_W-1:0]   slot_pos;
  logic [CFG_W-1:0]   slot_val;
  logic [CFG_W-1:0]   onehot_addr;
  logic [CFG_W-1:0]   pass_addr;
  logic [CFG_W-1:0]   type1_addr;

  cfgx_lowbit_find #(
    .W    (SEL_W),
    .BASE (SLOT_LSB),
    .PW   (POS_W)
  ) slot_find_i (
    .vec (idx[CFG_W-1:SLOT_LSB]),
    .hit (slot_hit),
    .pos (slot_pos)
  );

  always_comb begin
    if (idx[CFG_W-1])  mode = MAP_PASS;
    else if (idx[0])   mode = MAP_TYPE1;
    else               mode = MAP_ONEHOT;
  end

  always_comb begin
    pass_addr  = idx | CFG_W'(off_lo[1:0]);
    type1_addr = {idx[CFG_W-1:3], off_lo};
    slot_val   = slot_hit ? CFG_W'(slot_pos) : '1;
    onehot_addr = (slot_val << SLOT_LSB)
                | (CFG_W'(idx[FUNC_LSB +: FUNC_W]) << FUNC_LSB)
                | CFG_W'({idx[FUNC_LSB-1:REG_LSB], off_lo});
  end

  always_comb begin
    case (mode)
      MAP_PASS:  addr = pass_addr;
      MAP_TYPE1: addr = type1_addr;
      default:   addr = onehot_addr;
    endcase
  end
endmodule

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg
  import cfgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] idx_q
);
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst)                lane_q <= 8'h00;
        else if (we && be[l])   lane_q <= wdata[8*l +: 8];
      end
      assign idx_q[8*l +: 8] = lane_q;
    end
  endgenerate
endmodule

// File: rtl/cfgx_access_ctl.sv
module cfgx_access_ctl
  import cfgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_wr,
  input  logic             host_sel,
  input  logic [1:0]       host_off_lo,
  input  logic [1:0]       host_size,
  input  logic [CFG_W-1:0] host_wdata,
  output logic             host_ack,
  output logic [CFG_W-1:0] host_rdata,
  input  logic [CFG_W-1:0] xl_addr,
  input  logic [CFG_W-1:0] idx_q,
  output logic             idx_we,
  output logic [LANES-1:0] idx_be,
  output logic [CFG_W-1:0] idx_wdata,
  output logic             dn_valid,
  output logic             dn_wr,
  output logic [CFG_W-1:0] dn_addr,
  output logic [1:0]       dn_size,
  output logic [CFG_W-1:0] dn_wdata,
  input  logic             dn_ready,
  input  logic [CFG_W-1:0] dn_rdata
);
  ctl_state_e  state;
  xfer_size_e  req_sz;
  xfer_size_e  dn_sz_q;
  logic [4:0]  bit_shift;

  assign req_sz    = norm_size(host_size);
  assign bit_shift = {lane_shift(req_sz, host_off_lo), 3'b000};

  assign idx_we    = (state == ST_IDLE) && host_req && !host_sel && host_wr;
  assign idx_be    = lane_en(req_sz, host_off_lo);
  assign idx_wdata = host_wdata << bit_shift;
  assign dn_size   = dn_sz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      dn_valid   <= 1'b0;
      dn_wr      <= 1'b0;
      dn_addr    <= '0;
      dn_sz_q    <= SZ_B1;
      dn_wdata   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (host_req) begin
            if (host_sel) begin
              dn_valid <= 1'b1;
              dn_wr    <= host_wr;
              dn_addr  <= xl_addr;
              dn_sz_q  <= req_sz;
              dn_wdata <= host_wdata & size_mask(req_sz);
              state    <= ST_BUSY;
            end else begin
              host_ack   <= 1'b1;
              host_rdata <= host_wr ? '0 : ((idx_q >> bit_shift) & size_mask(req_sz));
              state      <= ST_DONE;
            end
          end
        end
        ST_BUSY: begin
          if (dn_ready) begin
            dn_valid   <= 1'b0;
            host_ack   <= 1'b1;
            host_rdata <= dn_wr ? '0 : (dn_rdata & size_mask(dn_sz_q));
            state      <= ST_DONE;
          end
        end
        ST_DONE: begin
          host_ack <= 1'b0;
          if (!host_req) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !dn_valid && !host_ack);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_wr)
                              && $stable(dn_size) && $stable(dn_wdata));
  // R7
  ack_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid && dn_ready |=> host_ack && !dn_valid);
  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfgx_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_wr,
  input  logic             host_sel,
  input  logic [OFF_W-1:0] host_off,
  input  logic [1:0]       host_size,
  input  logic [31:0]      host_wdata,
  output logic             host_ack,
  output logic [31:0]      host_rdata,
  output logic             dn_valid,
  output logic             dn_wr,
  output logic [31:0]      dn_addr,
  output logic [1:0]       dn_size,
  output logic [31:0]      dn_wdata,
  input  logic             dn_ready,
  input  logic [31:0]      dn_rdata
);
  logic [CFG_W-1:0] idx_q;
  logic [CFG_W-1:0] xl_addr;
  logic             idx_we;
  logic [LANES-1:0] idx_be;
  logic [CFG_W-1:0] idx_wdata;
  logic             unused_off_hi;

  assign unused_off_hi = ^host_off[OFF_W-1:3];

  cfgx_index_reg index_i (
    .clk   (clk),
    .rst   (rst),
    .we    (idx_we),
    .be    (idx_be),
    .wdata (idx_wdata),
    .idx_q (idx_q)
  );

  cfgx_addr_map map_i (
    .idx    (idx_q),
    .off_lo (host_off[2:0]),
    .addr   (xl_addr)
  );

  cfgx_access_ctl ctl_i (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_wr     (host_wr),
    .host_sel    (host_sel),
    .host_off_lo (host_off[1:0]),
    .host_size   (host_size),
    .host_wdata  (host_wdata),
    .host_ack    (host_ack),
    .host_rdata  (host_rdata),
    .xl_addr     (xl_addr),
    .idx_q       (idx_q),
    .idx_we      (idx_we),
    .idx_be      (idx_be),
    .idx_wdata   (idx_wdata),
    .dn_valid    (dn_valid),
    .dn_wr       (dn_wr),
    .dn_addr     (dn_addr),
    .dn_size     (dn_size),
    .dn_wdata    (dn_wdata),
    .dn_ready    (dn_ready),
    .dn_rdata    (dn_rdata)
  );

  // R3
  pass_map_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_valid) && $past(idx_q[31]) |-> dn_addr[31:2] == $past(idx_q[31:2]));
  // R4
  type1_map_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_valid) && $past(!idx_q[31] && idx_q[0]) |-> dn_addr[31:3] == $past(idx_q[31:3]));
  // R6
  empty_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_valid) && $past(idx_q[31:11] == '0 && !idx_q[0]) |-> &dn_addr[31:11]);
  // R5
  onehot_func_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_valid) && $past(!idx_q[31] && !idx_q[0])
      |-> dn_addr[10:3] == $past(idx_q[10:3]));
endmodule

// File: tb/cfg_addr_xlate_tb.sv
module cfg_addr_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [11:0] host_off = '0;
  logic [1:0]  host_size = 2'b10;
  logic [31:0] host_wdata = '0;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic        dn_valid;
  logic        dn_wr;
  logic [31:0] dn_addr;
  logic [1:0]  dn_size;
  logic [31:0] dn_wdata;
  logic        dn_ready = 1'b0;
  logic [31:0] dn_rdata = '0;

  int total = 0;
  int bad = 0;

  int          resp_lat = 0;
  logic [31:0] resp_data = '0;
  bit          in_txn = 0;
  int          wait_cnt = 0;
  int          drift = 0;
  logic [31:0] cap_addr;
  logic        cap_wr;
  logic [1:0]  cap_size;
  logic [31:0] cap_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_addr_xlate dut_i (
    .clk, .rst, .host_req, .host_wr, .host_sel, .host_off, .host_size,
    .host_wdata, .host_ack, .host_rdata, .dn_valid, .dn_wr, .dn_addr,
    .dn_size, .dn_wdata, .dn_ready, .dn_rdata
  );

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (dn_valid) begin
        if (!in_txn) begin
          in_txn = 1; wait_cnt = 0;
          cap_addr = dn_addr; cap_wr = dn_wr; cap_size = dn_size; cap_wdata = dn_wdata;
        end else if (dn_addr != cap_addr || dn_wr != cap_wr ||
                     dn_size != cap_size || dn_wdata != cap_wdata) begin
          drift++;
        end
        if (!dn_ready && wait_cnt >= resp_lat) begin
          dn_ready = 1'b1; dn_rdata = resp_data;
        end else begin
          dn_ready = 1'b0; wait_cnt++;
        end
      end else begin
        in_txn = 0; dn_ready = 1'b0; dn_rdata = 32'hBAD0_BAD0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] idx, input logic [11:0] off);
    logic [31:0] slot;
    if (idx[31]) return idx | {30'd0, off[1:0]};
    if (idx[0])  return {idx[31:3], off[2:0]};
    slot = 32'hFFFF_FFFF;
    for (int b = 31; b >= 11; b--) if (idx[b]) slot = b;
    return (slot << 11) | ({29'd0, idx[10:8]} << 8) | (idx & 32'h0000_00F8) | {29'd0, off[2:0]};
  endfunction

  task automatic host_op(input logic sel, input logic wr, input logic [11:0] off,
                         input logic [1:0] sz, input logic [31:0] wd,
                         output logic [31:0] rd, output logic pulse_ok);
    int n;
    @(negedge clk);
    host_req = 1'b1; host_sel = sel; host_wr = wr; host_off = off;
    host_size = sz; host_wdata = wd;
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!host_ack && n < 200);
    rd = host_rdata;
    host_req = 1'b0;
    @(negedge clk);
    pulse_ok = !host_ack && (n < 200);
  endtask

  task automatic idx_wr(input logic [11:0] off, input logic [1:0] sz, input logic [31:0] v);
    logic [31:0] rd; logic ok;
    host_op(1'b0, 1'b1, off, sz, v, rd, ok);
  endtask

  task automatic idx_rd_chk(input string tag, input logic [11:0] off,
                            input logic [1:0] sz, input logic [31:0] exp);
    logic [31:0] rd; logic ok;
    host_op(1'b0, 1'b0, off, sz, 32'h0, rd, ok);
    chk(tag, rd, exp);
  endtask

  task automatic data_chk(input string tag, input logic wr, input logic [11:0] off,
                          input logic [1:0] sz, input logic [31:0] wd, input int lat,
                          input logic [31:0] resp, input logic [31:0] e_addr,
                          input logic [1:0] e_size, input logic [31:0] e_wd,
                          input logic [31:0] e_rd);
    logic [31:0] rd; logic ok;
    resp_lat = lat; resp_data = resp; drift = 0;
    host_op(1'b1, wr, off, sz, wd, rd, ok);
    chk({tag, " addr"}, cap_addr, e_addr);
    chk({tag, " wr"}, {31'd0, cap_wr}, {31'd0, wr});
    chk({tag, " size"}, {30'd0, cap_size}, {30'd0, e_size});
    if (wr) chk({tag, " wdata"}, cap_wdata, e_wd);
    chk({tag, " rdata"}, rd, e_rd);
    chk({tag, " R7 held/pulse"}, {31'd0, ok && drift == 0}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 ack low", {31'd0, host_ack}, 32'd0);
    chk("R1 valid low", {31'd0, dn_valid}, 32'd0);
    idx_rd_chk("R1 index zero", 12'h000, 2'b10, 32'h0);
  endtask

  task automatic t_index_lanes;
    idx_wr(12'h000, 2'b00, 32'hAAAA_AA11);
    idx_wr(12'h001, 2'b00, 32'hBBBB_BB22);
    idx_wr(12'h002, 2'b01, 32'hCCCC_3344);
    idx_rd_chk("R2 full word", 12'h000, 2'b10, 32'h3344_2211);
    idx_rd_chk("R2 byte lane 3", 12'h003, 2'b00, 32'h0000_0033);
    idx_rd_chk("R2 half lane 2", 12'h002, 2'b01, 32'h0000_3344);
    idx_rd_chk("R2 byte lane 1", 12'h001, 2'b00, 32'h0000_0022);
    idx_wr(12'h7F0, 2'b11, 32'h8000_1234);
    idx_rd_chk("R2 alias word", 12'h000, 2'b10, 32'h8000_1234);
    idx_rd_chk("R2 alias read", 12'hFFC, 2'b10, 32'h8000_1234);
  endtask

  task automatic t_pass;
    idx_wr(12'h000, 2'b10, 32'h80AB_CD04);
    data_chk("R3 pass off3", 1'b0, 12'h003, 2'b10, 0, 0, 32'h1111_2222,
             32'h80AB_CD07, 2'b10, 0, 32'h1111_2222);
    data_chk("R10 pass high off", 1'b0, 12'h7F6, 2'b10, 0, 1, 32'h5555_6666,
             32'h80AB_CD06, 2'b10, 0, 32'h5555_6666);
    idx_wr(12'h000, 2'b10, 32'h8000_0801);
    data_chk("R3 bit31 over bit0", 1'b0, 12'h002, 2'b10, 0, 0, 32'h0,
             32'h8000_0803, 2'b10, 0, 32'h0);
  endtask

  task automatic t_type1;
    idx_wr(12'h000, 2'b10, 32'h00FF_1235);
    data_chk("R4 type1 off6", 1'b0, 12'h006, 2'b10, 0, 0, 32'h0,
             32'h00FF_1236, 2'b10, 0, 32'h0);
    data_chk("R10 type1 high off", 1'b0, 12'hA0F, 2'b10, 0, 2, 32'h0,
             32'h00FF_1237, 2'b10, 0, 32'h0);
  endtask

  task automatic t_onehot;
    logic [31:0] v;
    idx_wr(12'h000, 2'b10, 32'h0010_25A8);
    data_chk("R5 lowest of two", 1'b0, 12'h002, 2'b10, 0, 0, 32'h0,
             32'h0000_6DAA, 2'b10, 0, 32'h0);
    v = 32'h0000_0800;
    idx_wr(12'h000, 2'b10, v);
    data_chk("R5 slot 11", 1'b0, 12'h005, 2'b10, 0, 0, 32'h0,
             exp_addr(v, 12'h005), 2'b10, 0, 32'h0);
    v = 32'h4000_07F8;
    idx_wr(12'h000, 2'b10, v);
    data_chk("R5 slot 30", 1'b0, 12'hFF7, 2'b10, 0, 0, 32'h0,
             32'h0000_F7FF, 2'b10, 0, 32'h0);
  endtask

  task automatic t_noslot;
    idx_wr(12'h000, 2'b10, 32'h0000_0300);
    data_chk("R6 empty slot", 1'b0, 12'h001, 2'b10, 0, 0, 32'h0,
             32'hFFFF_FB01, 2'b10, 0, 32'h0);
  endtask

  task automatic t_sizes;
    idx_wr(12'h000, 2'b10, 32'h8000_0000);
    data_chk("R8 byte write", 1'b1, 12'h001, 2'b00, 32'hDEAD_BEEF, 0, 32'h0,
             32'h8000_0001, 2'b00, 32'h0000_00EF, 32'h0);
    data_chk("R8 half read", 1'b0, 12'h002, 2'b01, 0, 1, 32'h1234_5678,
             32'h8000_0002, 2'b01, 0, 32'h0000_5678);
    data_chk("R8 code 11 read", 1'b0, 12'h000, 2'b11, 0, 0, 32'hCAFE_F00D,
             32'h8000_0000, 2'b10, 0, 32'hCAFE_F00D);
    data_chk("R8 word write", 1'b1, 12'h000, 2'b10, 32'h0102_0304, 0, 32'hFFFF_FFFF,
             32'h8000_0000, 2'b10, 32'h0102_0304, 32'h0);
  endtask

  task automatic t_wait_states;
    idx_wr(12'h000, 2'b10, 32'h0000_4301);
    data_chk("R7 long wait", 1'b1, 12'h004, 2'b01, 32'hABCD_9876, 9, 32'h0,
             32'h0000_4304, 2'b01, 32'h0000_9876, 32'h0);
  endtask

  task automatic t_fresh_index;
    idx_wr(12'h000, 2'b10, 32'h0000_0801);
    data_chk("R9 first index", 1'b0, 12'h000, 2'b10, 0, 0, 32'h0,
             32'h0000_0800, 2'b10, 0, 32'h0);
    idx_wr(12'h003, 2'b00, 32'h0000_0002);
    data_chk("R9 updated index", 1'b0, 12'h000, 2'b10, 0, 0, 32'h0,
             exp_addr(32'h0200_0801, 12'h000), 2'b10, 0, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", {31'd0, dn_valid}, 32'd0);
    rst = 1'b0;
    t_reset();
    t_index_lanes();
    t_pass();
    t_type1();
    t_onehot();
    t_noslot();
    t_sizes();
    t_wait_states();
    t_fresh_index();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule